// File: doc/BRIEF.md
# USB Charging-Port Detection Sequencer

This block sequences the detection of a battery-charging source on the USB data lines. It drives the enables of the analog detection circuitry as a 7-bit control word and reads back digital comparator and receiver outputs. Those inputs are resynchronised to the system clock and debounced against a slow charger-clock strobe. The run ends in one of two classes: a 500 mA charger or a 100 mA supply. An optional data-contact phase can run before classification. It ends when the data-plus line shows contact or when a timeout expires.

Software may take control at any moment. On the edge where it does, four context flags are captured. The sequencer then freezes, and the control word follows the software-supplied value until control is handed back. The slow clock is a single-cycle strobe, `slow_tick`, in the system clock domain. Every debounce window and timeout counts these strobes.

Top module: `chgdet_ctrl`

## Requirements
- R1: After reset, `ctrl_word` is 0, all four context flags are 0, `vbus_valid` is 0 and both single-ended status bits are 0.
- R2: `vbus_valid` rises only after `vbus_cmp` has been seen high on `VBUS_DEB_TICKS` consecutive slow ticks while `batt_present` is 1. It drops on the first slow tick that sees `vbus_cmp` low. It drops one clock after `batt_present` goes low.
- R3: The sequencer leaves idle (control word 0) only while `hw_det_en`, `det_start` and `vbus_valid` are all 1.
- R4: Control-word bit map: bit 6 is the 500 mA result, bit 5 the 100 mA result, bit 4 the detector bias enable, bit 3 the data-plus current source and data-minus pulldown, bit 2 the data-plus voltage source, data-minus sink and comparator, bit 1 the single-ended receivers, and bit 0 is reserved (always 0). With `dcd_en` = 1 a run starts in the data-contact phase with word 0x3A.
- R5: The data-contact phase moves to charger detection (word 0x14) on the first slow tick that sees `se_dp` low. Otherwise it moves on the `DCD_TICKS`-th slow tick spent in the phase.
- R6: With `dcd_en` = 0 a run starts directly in charger detection with word 0x14.
- R7: In charger detection, `type_cmp` is debounced over `CHG_DEB_TICKS` slow ticks, and any change restarts the count. A settled 1 gives word 0x40 (500 mA) and a settled 0 gives word 0x20 (100 mA). A result is only entered from charger detection.
- R8: A result is held until `vbus_valid`, `det_start` or `hw_det_en` drops. The sequencer then returns to idle, word 0.
- R9: While `sw_ctrl` is 1, `ctrl_word` bits 6..1 equal `sw_word` bits 6..1 and bit 0 is 0. Bit 3 comes from `sw_word` even when the sequencer had it set.
- R10: On the rising edge of `sw_ctrl` the context flags capture four values: hardware-detect active (not idle), the current word's bit 2, the debounced charger-type value, and the synchronised raw `type_cmp`. They then stay unchanged until the next rising edge of `sw_ctrl`.
- R11: While `sw_ctrl` is 1 the sequencer state and the data-contact timer are frozen. Detection resumes from the same point after release.
- R12: `se_dp_stat` and `se_dm_stat` show `se_dp` and `se_dm` after `SYNC_STAGES` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe of the slow charger clock |
| hw_det_en | input | 1 | Hardware detection enable |
| det_start | input | 1 | Start bit; clearing it aborts or restarts detection |
| dcd_en | input | 1 | Run the data-contact phase first |
| batt_present | input | 1 | Battery present; VBUS is qualified only while 1 |
| vbus_cmp | input | 1 | Raw VBUS comparator output |
| type_cmp | input | 1 | Raw charger-type comparator output |
| se_dp | input | 1 | Data-plus single-ended receiver output |
| se_dm | input | 1 | Data-minus single-ended receiver output |
| sw_ctrl | input | 1 | Software takeover |
| sw_word | input | 7 | Software control word used during takeover |
| ctrl_word | output | 7 | Control word to the detection circuitry |
| vbus_valid | output | 1 | Debounced, battery-qualified VBUS presence |
| ctx_hwdet | output | 1 | Captured: detection was active |
| ctx_dpsrc | output | 1 | Captured: data-plus voltage source enable |
| ctx_vdat | output | 1 | Captured: debounced charger-type value |
| ctx_comp | output | 1 | Captured: raw charger-type comparator |
| se_dp_stat | output | 1 | Synchronised data-plus receiver status |
| se_dm_stat | output | 1 | Synchronised data-minus receiver status |

## Verification
Raw comparator inputs reach the debouncers after `SYNC_STAGES` clocks. A debounced flag changes one clock after the qualifying slow tick. The control word follows one clock after that. Context flags update one clock after `sw_ctrl` rises, and the software word reaches `ctrl_word` combinationally. The bench therefore changes inputs on falling edges and leaves at least three clocks between an input change and the next slow tick. It samples three clocks after each tick or input change, so every result has settled, and it counts ticks exactly so that each window is checked one tick before and on its boundary.

// File: rtl/chgdet_pkg.sv
package chgdet_pkg;

  localparam int CW_BITS = 7;

  // control word bit positions
  localparam int B_RES500 = 6;
  localparam int B_RES100 = 5;
  localparam int B_BIAS   = 4;
  localparam int B_IDP    = 3;
  localparam int B_VDP    = 2;
  localparam int B_SERX   = 1;
  localparam int B_RSVD   = 0;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DCD    = 3'd1,
    ST_CHG    = 3'd2,
    ST_RES100 = 3'd3,
    ST_RES500 = 3'd4
  } chg_state_e;

  function automatic logic [CW_BITS-1:0] state_word(input chg_state_e s);
    logic [CW_BITS-1:0] w;
    w = '0;
    case (s)
      ST_DCD: begin
        w[B_RES100] = 1'b1;
        w[B_BIAS]   = 1'b1;
        w[B_IDP]    = 1'b1;
        w[B_SERX]   = 1'b1;
      end
      ST_CHG: begin
        w[B_BIAS] = 1'b1;
        w[B_VDP]  = 1'b1;
      end
      ST_RES100: w[B_RES100] = 1'b1;
      ST_RES500: w[B_RES500] = 1'b1;
      default:   w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/chgdet_sync.sv
module chgdet_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= '0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/chgdet_debounce.sv
module chgdet_debounce #(
  parameter int TICKS = 328
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  input  logic d,
  output logic q,
  output logic settled
);

  localparam int CNT_W = $clog2(TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TICKS);

  logic             cur_q, cur_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign upd = clr | tick;

  always_comb begin
    cur_d = cur_q;
    cnt_d = cnt_q;
    if (clr) begin
      cur_d = 1'b0;
      cnt_d = '0;
    end else if (tick) begin
      if (d != cur_q) begin
        cur_d = d;
        cnt_d = CNT_W'(1);
      end else if (cnt_q != CNT_MAX) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      cur_q <= cur_d;
      cnt_q <= cnt_d;
    end
  end

  assign q       = cur_q;
  assign settled = (cnt_q == CNT_MAX);

endmodule

// File: rtl/chgdet_fsm.sv
module chgdet_fsm
  import chgdet_pkg::*;
#(
  parameter int DCD_TICKS = 9830
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               freeze,
  input  logic               run,
  input  logic               vbus_ok,
  input  logic               dcd_en,
  input  logic               contact,
  input  logic               type_settled,
  input  logic               type_q,
  output logic [CW_BITS-1:0] word,
  output logic               busy,
  output logic               in_chg
);

  localparam int TMR_W = (DCD_TICKS > 1) ? $clog2(DCD_TICKS) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(DCD_TICKS - 1);

  chg_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             st_en, tmr_en;

  assign st_en = ~freeze;

  always_comb begin
    st_d = st_q;
    if (!run || !vbus_ok) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: st_d = dcd_en ? ST_DCD : ST_CHG;
        ST_DCD:  if (tick && (contact || tmr_q == TMR_LAST)) st_d = ST_CHG;
        ST_CHG:  if (type_settled) st_d = type_q ? ST_RES500 : ST_RES100;
        ST_RES100, ST_RES500: st_d = st_q;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_d = tmr_q;
    if (st_q != ST_DCD) tmr_d = '0;
    else if (tick && tmr_q != TMR_LAST) tmr_d = tmr_q + 1'b1;
  end
  assign tmr_en = ~freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_IDLE;
    else if (st_en) st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  assign word   = state_word(st_q);
  assign busy   = (st_q != ST_IDLE);
  assign in_chg = (st_q == ST_CHG);

endmodule

// File: rtl/chgdet_ctrl.sv
module chgdet_ctrl
  import chgdet_pkg::*;
#(
  parameter int VBUS_DEB_TICKS = 328,
  parameter int CHG_DEB_TICKS  = 656,
  parameter int DCD_TICKS      = 9830,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       hw_det_en,
  input  logic       det_start,
  input  logic       dcd_en,
  input  logic       batt_present,
  input  logic       vbus_cmp,
  input  logic       type_cmp,
  input  logic       se_dp,
  input  logic       se_dm,
  input  logic       sw_ctrl,
  input  logic [6:0] sw_word,
  output logic [6:0] ctrl_word,
  output logic       vbus_valid,
  output logic       ctx_hwdet,
  output logic       ctx_dpsrc,
  output logic       ctx_vdat,
  output logic       ctx_comp,
  output logic       se_dp_stat,
  output logic       se_dm_stat
);

  localparam int NSYNC = 4;

  logic [NSYNC-1:0]   raw_in, syn_in;
  logic               vbus_s, type_s;
  logic               vbus_q, vbus_settled;
  logic               type_q, type_settled;
  logic [CW_BITS-1:0] fsm_word;
  logic               fsm_busy, fsm_in_chg;
  logic               sw_ctrl_q;
  logic               take_edge;
  logic [3:0]         ctx_q, ctx_d;

  assign raw_in = {vbus_cmp, type_cmp, se_dp, se_dm};

  chgdet_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in)
  );

  assign vbus_s     = syn_in[3];
  assign type_s     = syn_in[2];
  assign se_dp_stat = syn_in[1];
  assign se_dm_stat = syn_in[0];

  chgdet_debounce #(.TICKS(VBUS_DEB_TICKS)) u_vbus_deb (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .clr(~batt_present),
    .d(vbus_s), .q(vbus_q), .settled(vbus_settled)
  );

  assign vbus_valid = vbus_q & vbus_settled;

  chgdet_debounce #(.TICKS(CHG_DEB_TICKS)) u_type_deb (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .clr(~fsm_in_chg),
    .d(type_s), .q(type_q), .settled(type_settled)
  );

  chgdet_fsm #(.DCD_TICKS(DCD_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(slow_tick), .freeze(sw_ctrl),
    .run(hw_det_en & det_start), .vbus_ok(vbus_valid), .dcd_en(dcd_en),
    .contact(~se_dp_stat), .type_settled(type_settled), .type_q(type_q),
    .word(fsm_word), .busy(fsm_busy), .in_chg(fsm_in_chg)
  );

  // takeover edge and context capture
  assign take_edge = sw_ctrl & ~sw_ctrl_q;
  assign ctx_d     = {fsm_busy, fsm_word[B_VDP], type_q, type_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_ctrl_q <= 1'b0;
    else        sw_ctrl_q <= sw_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctx_q <= '0;
    else if (take_edge) ctx_q <= ctx_d;
  end

  assign {ctx_hwdet, ctx_dpsrc, ctx_vdat, ctx_comp} = ctx_q;

  always_comb begin
    ctrl_word         = sw_ctrl ? sw_word : fsm_word;
    ctrl_word[B_RSVD] = 1'b0;
  end

endmodule

// File: rtl/chgdet_ctrl_chk.sv
module chgdet_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_ctrl,
  input logic       sw_ctrl_q,
  input logic       batt_present,
  input logic       hw_det_en,
  input logic       det_start,
  input logic       vbus_valid,
  input logic [6:0] fsm_word,
  input logic [3:0] ctx_q
);

  // R2: no battery means VBUS is not qualified on the next cycle
  p_vbus_needs_batt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_present |=> !vbus_valid);

  // R3: idle is kept unless all start conditions hold
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_word == 7'd0 && !(hw_det_en && det_start && vbus_valid)) |=> fsm_word == 7'd0);

  // R7: a 500 mA result is entered only from charger detection
  p_res_from_chg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsm_word[6]) |-> $past(fsm_word[2]));

  // R8: VBUS loss returns to idle
  p_vbus_loss_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!vbus_valid && !sw_ctrl) |=> fsm_word == 7'd0);

  // R8: a result is held while the run conditions stay true
  p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((fsm_word[6] || fsm_word == 7'h20) && !sw_ctrl && hw_det_en && det_start && vbus_valid)
      |=> $stable(fsm_word));

  // R10: captured context is stable after the takeover edge
  p_ctx_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ctrl && sw_ctrl_q) |=> $stable(ctx_q));

  // R11: the sequencer does not move while software holds control
  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ctrl |=> $stable(fsm_word));

endmodule

bind chgdet_ctrl chgdet_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_ctrl(sw_ctrl), .sw_ctrl_q(sw_ctrl_q),
  .batt_present(batt_present), .hw_det_en(hw_det_en), .det_start(det_start),
  .vbus_valid(vbus_valid), .fsm_word(fsm_word), .ctx_q(ctx_q)
);

// File: tb/chgdet_ctrl_bench.sv
module chgdet_ctrl_bench;

  localparam int VB  = 4;
  localparam int CHG = 6;
  localparam int DCD = 5;

  localparam logic [6:0] W_IDLE = 7'h00;
  localparam logic [6:0] W_DCD  = 7'h3A;
  localparam logic [6:0] W_CHG  = 7'h14;
  localparam logic [6:0] W_500  = 7'h40;
  localparam logic [6:0] W_100  = 7'h20;

  logic clk = 1'b0;
  logic rst_n;
  logic slow_tick, hw_det_en, det_start, dcd_en, batt_present;
  logic vbus_cmp, type_cmp, se_dp, se_dm, sw_ctrl;
  logic [6:0] sw_word;
  logic [6:0] ctrl_word;
  logic vbus_valid, ctx_hwdet, ctx_dpsrc, ctx_vdat, ctx_comp, se_dp_stat, se_dm_stat;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  chgdet_ctrl #(
    .VBUS_DEB_TICKS(VB), .CHG_DEB_TICKS(CHG), .DCD_TICKS(DCD), .SYNC_STAGES(2)
  ) u_chgdet_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .hw_det_en(hw_det_en),
    .det_start(det_start), .dcd_en(dcd_en), .batt_present(batt_present),
    .vbus_cmp(vbus_cmp), .type_cmp(type_cmp), .se_dp(se_dp), .se_dm(se_dm),
    .sw_ctrl(sw_ctrl), .sw_word(sw_word), .ctrl_word(ctrl_word),
    .vbus_valid(vbus_valid), .ctx_hwdet(ctx_hwdet), .ctx_dpsrc(ctx_dpsrc),
    .ctx_vdat(ctx_vdat), .ctx_comp(ctx_comp), .se_dp_stat(se_dp_stat),
    .se_dm_stat(se_dm_stat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) slow_tick = 1'b1;
    @(negedge clk) slow_tick = 1'b0;
    settle();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic logic [3:0] ctx();
    return {ctx_hwdet, ctx_dpsrc, ctx_vdat, ctx_comp};
  endfunction

  task automatic qualify_vbus();
    batt_present = 1'b1;
    vbus_cmp     = 1'b1;
    settle();
    ticks(VB - 1);
    chk("R2 vbus before window", vbus_valid, 0);
    tick();
    chk("R2 vbus at window", vbus_valid, 1);
  endtask

  task automatic run_case(input bit dcd, input bit tmo, input bit typ);
    dcd_en   = dcd;
    se_dp    = 1'b1;
    type_cmp = typ;
    settle();
    det_start = 1'b1;
    settle();
    chk(dcd ? "R4 dcd entry word" : "R6 direct entry word", ctrl_word, dcd ? W_DCD : W_CHG);
    if (dcd) begin
      if (tmo) begin
        ticks(DCD - 1);
        chk("R5 before timeout", ctrl_word, W_DCD);
        tick();
        chk("R5 timeout exit", ctrl_word, W_CHG);
      end else begin
        tick();
        chk("R5 no contact yet", ctrl_word, W_DCD);
        se_dp = 1'b0;
        settle();
        tick();
        chk("R5 contact exit", ctrl_word, W_CHG);
      end
    end
    ticks(CHG - 1);
    chk("R7 before debounce", ctrl_word, W_CHG);
    tick();
    chk("R7 result word", ctrl_word, typ ? W_500 : W_100);
    ticks(3);
    chk("R8 result held", ctrl_word, typ ? W_500 : W_100);
    det_start = 1'b0;
    settle();
    chk("R8 restart to idle", ctrl_word, W_IDLE);
    se_dp = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0;
    slow_tick = 0; hw_det_en = 0; det_start = 0; dcd_en = 0; batt_present = 0;
    vbus_cmp = 0; type_cmp = 0; se_dp = 0; se_dm = 0; sw_ctrl = 0; sw_word = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 ctrl_word", ctrl_word, 0);
    chk("R1 context", ctx(), 0);
    chk("R1 vbus_valid", vbus_valid, 0);
    chk("R1 se status", {se_dp_stat, se_dm_stat}, 0);

    // R12 receiver status sweep
    for (int i = 0; i < 4; i++) begin
      se_dp = i[1];
      se_dm = i[0];
      settle();
      chk("R12 se status", {se_dp_stat, se_dm_stat}, i);
    end
    se_dp = 1'b1; se_dm = 1'b0;

    // R2 battery gating
    batt_present = 1'b0;
    vbus_cmp     = 1'b1;
    settle();
    ticks(VB + 2);
    chk("R2 no battery", vbus_valid, 0);
    qualify_vbus();

    // R3 start conditions
    hw_det_en = 1'b0; det_start = 1'b1;
    settle(); tick();
    chk("R3 no hw enable", ctrl_word, W_IDLE);
    hw_det_en = 1'b1; det_start = 1'b0;
    settle(); tick();
    chk("R3 no start", ctrl_word, W_IDLE);

    // sweep: dcd on/off, contact/timeout, charger type
    for (int d = 0; d < 2; d++)
      for (int m = 0; m < 2; m++)
        for (int t = 0; t < 2; t++)
          run_case(d[0], m[0], t[0]);

    // R7 change during debounce restarts the count
    dcd_en = 1'b0; type_cmp = 1'b1; settle();
    det_start = 1'b1; settle();
    ticks(3);
    type_cmp = 1'b0; settle();
    ticks(CHG - 1);
    chk("R7 restart after change", ctrl_word, W_CHG);
    tick();
    chk("R7 restarted result", ctrl_word, W_100);

    // R8 VBUS loss
    vbus_cmp = 1'b0; settle(); tick();
    chk("R8 vbus dropped", vbus_valid, 0);
    chk("R8 idle on vbus loss", ctrl_word, W_IDLE);
    det_start = 1'b0;
    qualify_vbus();

    // R9 R10 R11 takeover during data-contact phase
    dcd_en = 1'b1; se_dp = 1'b1; type_cmp = 1'b1; settle();
    det_start = 1'b1; settle();
    ticks(2);
    sw_word = 7'b101_0101;
    sw_ctrl = 1'b1;
    settle();
    chk("R9 software word", ctrl_word, 7'h54);
    chk("R10 context in dcd", ctx(), 4'b1001);
    type_cmp = 1'b0; settle();
    ticks(DCD + 2);
    chk("R10 context held", ctx(), 4'b1001);
    sw_word = 7'b010_1011;
    settle();
    chk("R9 software word change", ctrl_word, 7'h2A);
    sw_ctrl = 1'b0;
    settle();
    chk("R11 resumed in dcd", ctrl_word, W_DCD);
    ticks(DCD - 3);
    chk("R11 timer frozen", ctrl_word, W_DCD);
    tick();
    chk("R11 timeout after resume", ctrl_word, W_CHG);

    // R10 takeover during charger detection
    type_cmp = 1'b1; settle();
    ticks(2);
    sw_ctrl = 1'b1;
    settle();
    chk("R10 context in chg", ctx(), 4'b1111);
    det_start = 1'b0; sw_ctrl = 1'b0;
    settle();
    chk("R8 idle after release", ctrl_word, W_IDLE);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule